// File: doc/BRIEF.md
# Two-Ninths Dual-Edge Clock Divider

This block derives a slower clock from a fast input clock at an average ratio of two output periods for every nine input periods. Nine input cycles is an odd count, so the two output pulses in each frame cannot both start on rising input edges if they are to be evenly spaced. One pulse is launched from a rising edge and the other from a falling edge, which puts their leading edges 4.5 input cycles apart.

A nine-stage one-hot ring advances on each rising input edge. Two small tap banks sample selected ring stages, one bank on rising edges and one on falling edges. The output is the OR of all taps. Each pulse lasts two input cycles, so the output is high for 4 of every 9 input cycles with a balanced input clock. In each pulse a tap from the opposite edge bank stays high across the moment where two same-edge taps hand over, so the OR never dips low inside a pulse.

Top module: `frac_clk_div_2_9`

## Requirements
- R1: The ring is 9 bits wide and holds exactly one set bit. A rising edge with `rst` high loads bit 0 only. Every other rising edge rotates the ring left by one, with bit 8 wrapping into bit 0.
- R2: Reset is synchronous and active high. After the first falling edge that follows a rising edge with `rst` high, `clk_out` is low and stays low for as long as `rst` stays high.
- R3: The rising-edge taps sample ring bits 1, 2 and 6. The falling-edge taps sample ring bits 2, 6 and 7. `clk_out` is the OR of the six taps and is low in every half-cycle outside the two pulses.
- R4: Number the rising edges from 1, where edge 1 is the first rising edge with `rst` low. The first pulse is high from rising edge 2 to rising edge 4.
- R5: The second pulse is high from the falling edge that follows rising edge 6 to the falling edge that follows rising edge 8.
- R6: The pattern repeats every 9 input cycles. Each 9-cycle frame has exactly two rising edges on `clk_out` and exactly 8 high half-cycles, which is 4 input cycles.
- R7: With a 50% input clock, the time from one output rising edge to the next is 4.5 input periods, in both halves of the frame.
- R8: A same-edge hand-over inside a pulse happens only while a tap from the opposite edge bank is high. This covers the rising-bank change at rising edge 3 and the falling-bank change after rising edge 7.
- R9: At most one tap in each bank is high at any time.
- R10: Let the input be high for H per period T. The spacing between output rising edges is then 4T + H from the first pulse to the second, and 5T - H from the second pulse to the next first pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock. Both of its edges are used. |
| rst | input | 1 | Synchronous reset, active high |
| clk_out | output | 1 | Divided clock at 2/9 of the input frequency |

## Verification
The assertions check the ring's one-hot state and its rotation on every rising edge. They also check that each tap bank has at most one tap high, and that every same-edge hand-over inside a pulse is covered by a high tap from the other bank. The bench scenarios sample the output in every half-cycle, so only they can show the absolute pulse positions after reset, the two-rise and eight-half-cycle count in each frame, and the clearing of the output by a reset that arrives in the middle of a pulse. Only the bench can show the edge spacing under a balanced input clock and under a skewed one, because it measures real time between output edges.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Selects which edge of the input clock a tap bank samples on
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

endpackage

// File: rtl/frac_div_ring.sv
module frac_div_ring #(
  parameter int LEN = 9
) (
  input  logic           clk,
  input  logic           rst,
  output logic [LEN-1:0] ring
);

  localparam logic [LEN-1:0] SEED = LEN'(1);

  always_ff @(posedge clk) begin
    if (rst) ring <= SEED;
    else     ring <= {ring[LEN-2:0], ring[LEN-1]};
  end

  // R1: exactly one stage set while running
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(ring));

  // R1: left rotation with wrap from the top stage
  p_rotate_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ring == {$past(ring[LEN-2:0]), $past(ring[LEN-1])});

endmodule

// File: rtl/frac_div_tap_bank.sv
module frac_div_tap_bank
  import frac_div_pkg::*;
#(
  parameter int             LEN  = 9,
  parameter logic [LEN-1:0] MASK = '0,
  parameter edge_e          EDGE = EDGE_RISE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LEN-1:0] ring,
  output logic [LEN-1:0] tap_q,
  output logic           any_q
);

  // Unselected stages become constant-zero flops and are trimmed away
  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= ring & MASK;
      end
      // R9: one tap at a time in this bank
      p_single_tap_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_q) <= 1);
    end else begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= ring & MASK;
      end
      // R9: one tap at a time in this bank
      p_single_tap_r9: assert property (@(negedge clk) disable iff (rst)
        $countones(tap_q) <= 1);
    end
  endgenerate

  assign any_q = |tap_q;

endmodule

// File: rtl/frac_clk_div_2_9.sv
module frac_clk_div_2_9
  import frac_div_pkg::*;
#(
  parameter int                  RING_LEN  = 9,
  parameter logic [RING_LEN-1:0] RISE_SEL  = RING_LEN'(9'b001000110),
  parameter logic [RING_LEN-1:0] FALL_SEL  = RING_LEN'(9'b011000100)
) (
  input  logic clk,
  input  logic rst,
  output logic clk_out
);

  logic [RING_LEN-1:0] ring;
  logic [RING_LEN-1:0] rise_q;
  logic [RING_LEN-1:0] fall_q;
  logic                rise_any;
  logic                fall_any;

  frac_div_ring #(.LEN(RING_LEN)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .ring (ring)
  );

  frac_div_tap_bank #(.LEN(RING_LEN), .MASK(RISE_SEL), .EDGE(EDGE_RISE)) u_rise (
    .clk   (clk),
    .rst   (rst),
    .ring  (ring),
    .tap_q (rise_q),
    .any_q (rise_any)
  );

  frac_div_tap_bank #(.LEN(RING_LEN), .MASK(FALL_SEL), .EDGE(EDGE_FALL)) u_fall (
    .clk   (clk),
    .rst   (rst),
    .ring  (ring),
    .tap_q (fall_q),
    .any_q (fall_any)
  );

  assign clk_out = rise_any | fall_any;

  // R8: a rising-bank hand-over is bridged by a falling tap held across it
  p_cover_rise_r8: assert property (@(negedge clk) disable iff (rst)
    ($past(|rise_q) && (|rise_q) && (rise_q != $past(rise_q))) |-> (|fall_q));

  // R8: a falling-bank hand-over is bridged by a rising tap held across it
  p_cover_fall_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(|fall_q) && (|fall_q) && (fall_q != $past(fall_q))) |-> (|rise_q));

endmodule

// File: tb/tb_frac_clk_div_2_9.sv
`timescale 1ns/1ps
module tb_frac_clk_div_2_9;

  localparam real PER = 4.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_out;
  real  hi_ns = 2.0;
  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc = 0;

  frac_clk_div_2_9 dut (.clk(clk), .rst(rst), .clk_out(clk_out));

  always begin
    #(PER - hi_ns) clk = 1'b1;
    #(hi_ns)       clk = 1'b0;
  end

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary_and_end();
    end
  end

  task automatic chk_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_time(string req, real act, real exp);
    n_checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      n_errors++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  // R2: hold reset, check output low, release so next rising edge is edge 1
  task automatic apply_reset();
    @(negedge clk); #1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    chk_bit("R2 low in reset", clk_out, 1'b0);
    @(negedge clk); #1;
    rst = 1'b0;
  endtask

  function automatic string slot_req(int m);
    if (m == 3 || m == 7) return "R8,R9 bridged";
    if (m == 2 || m == 4) return "R4 first pulse";
    if (m == 6 || m == 8) return "R5 second pulse";
    return "R3 idle slot";
  endfunction

  // Sample every half-cycle for n cycles starting at edge 1
  task automatic run_pattern(int n);
    logic prev = 1'b0;
    int rises = 0;
    int highs = 0;
    for (int k = 1; k <= n; k++) begin
      int  m;
      logic e_first;
      logic e_second;
      m = k % 9;
      e_first  = (m == 2 || m == 3 || m == 7 || m == 8);
      e_second = (m == 2 || m == 3 || m == 6 || m == 7);
      @(posedge clk); #0.5;
      chk_bit(slot_req(m), clk_out, e_first);
      if (clk_out && !prev) rises++;
      if (clk_out) highs++;
      prev = clk_out;
      @(negedge clk); #0.5;
      chk_bit(slot_req(m), clk_out, e_second);
      if (clk_out && !prev) rises++;
      if (clk_out) highs++;
      prev = clk_out;
      if (m == 0) begin
        chk_int("R6 rises per frame", rises, 2);
        chk_int("R6 high halves per frame", highs, 8);
        rises = 0;
        highs = 0;
      end
    end
  endtask

  task automatic test_power_on();
    apply_reset();
    run_pattern(9);
  endtask

  task automatic test_long_run();
    apply_reset();
    run_pattern(90); // R1 ring stays one-hot: pattern repeats for ten frames
  endtask

  // R2: reset in the middle of the second pulse clears the output
  task automatic test_mid_reset();
    apply_reset();
    repeat (7) @(posedge clk);
    @(negedge clk); #0.5;
    chk_bit("R5 high before reset", clk_out, 1'b1);
    #0.5;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk); #0.5;
    chk_bit("R2 cleared by mid-pulse reset", clk_out, 1'b0);
    repeat (4) begin
      @(posedge clk); #0.5;
      chk_bit("R2 held low", clk_out, 1'b0);
    end
    @(negedge clk); #1;
    rst = 1'b0;
    run_pattern(18);
  endtask

  // R7 and R10: measured spacing between output rising edges
  task automatic test_spacing(real h, string req);
    real t1, t2, t3;
    @(negedge clk); #1;
    hi_ns = h;
    apply_reset();
    @(posedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    @(posedge clk_out); t3 = $realtime;
    chk_time(req, t2 - t1, 4.0 * PER + h);
    chk_time(req, t3 - t2, 5.0 * PER - h);
  endtask

  initial begin
    test_power_on();
    test_long_run();
    test_mid_reset();
    test_spacing(2.0, "R7 balanced spacing");
    test_spacing(1.5, "R10 skewed spacing");
    test_spacing(2.5, "R10 skewed spacing");
    summary_and_end();
  end

endmodule